// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver

This block is a receive-only target on a two-wire I2C bus. A fast system clock oversamples the clock line and the data line. Both lines are cleaned up before use, and the block finds bus START and STOP events in the cleaned signals. It shifts in bytes, checks whether the first byte of a transaction carries its own address, and then takes any number of command bytes.

There is no register pointer. Each byte after the address is a self-contained command. It is handed downstream on `cmd_data` with a strobe one system clock wide. The only time the block touches the bus is to pull the data line low during the acknowledge clock of a byte it accepts.

Top module: `i2c_cmd_rx`

## Requirements
- R1: While reset is asserted, and right after it, `sda_pull` is 0 and `cmd_valid` is 0.
- R2: The first byte after a START is accepted only if it equals {1,1,0,1,1,1,`addr_sel`,0}, received MSB first. With `addr_sel`=0 that byte is 0xDC, and with `addr_sel`=1 it is 0xDE. An accepted address byte is acknowledged: the data line is held low during the ninth clock.
- R3: An address byte with any other value, including a bit-0 (read/write) value of 1, gets no acknowledge. No byte after it gets an acknowledge or a strobe until the next START or STOP.
- R4: Once the block is addressed, each later byte appears on `cmd_data` in MSB-first order. `cmd_valid` is high for exactly one clock cycle, starting at the clock-line falling edge that ends the byte's eighth bit.
- R5: Every data byte of an addressed transaction is acknowledged. The data line is held low for the whole ninth clock.
- R6: A transaction may carry any number of data bytes. All of them are delivered in order.
- R7: A STOP in the middle of a byte discards the partial byte, and no strobe is produced for it. The next transaction works normally.
- R8: A repeated START in the middle of a byte abandons that byte and starts address matching again. This includes a repeated START after a rejected address.
- R9: A low pulse on the clock line that lasts fewer than 3 system clocks, inside a high phase, is ignored and does not add a bit.
- R10: `sda_pull` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| addr_sel | input | 1 | Strap that sets address bit 1 |
| sda_pull | output | 1 | 1 = pull the data line low (open-drain enable) |
| cmd_data | output | 8 | Last received command byte |
| cmd_valid | output | 1 | One-cycle strobe for `cmd_data` |

## Verification
The hardest states to reach from the ports are a byte cut off by a STOP or a repeated START partway through, and a clock line with a glitch inside a high phase. The bench reaches them with a bit-level bus driver that can stop after any number of bits or narrow a high phase with a 2-cycle low pulse. It then checks that no strobe is produced, or that the byte is still correct. Address matching is swept over all 256 first-byte values with a trailing data byte, so both the acknowledge and the silence that follows a rejection are observed at the ports.

// File: rtl/i2c_cmd_rx_pkg.sv
package i2c_cmd_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_ACK,
    RX_SKIP
  } rx_state_t;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int LINE_NUM = 2;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int N     = 2,
  parameter int SYNC  = 2,
  parameter int FILT  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [SYNC-1:0] sy_q, sy_d;
    logic [FILT-1:0] win_q, win_d;
    logic            lvl_q, lvl_d, prv_q;

    // next state: synchronizer shift, sample window, hysteresis level
    always_comb begin
      sy_d  = {sy_q[SYNC-2:0], din[g]};
      win_d = {win_q[FILT-2:0], sy_q[SYNC-1]};
      lvl_d = lvl_q;
      if (&win_q) begin
        lvl_d = 1'b1;
      end else if (~|win_q) begin
        lvl_d = 1'b0;
      end
    end

    // bus lines idle high, so reset to 1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy_q  <= '1;
        win_q <= '1;
        lvl_q <= 1'b1;
        prv_q <= 1'b1;
      end else begin
        sy_q  <= sy_d;
        win_q <= win_d;
        lvl_q <= lvl_d;
        prv_q <= lvl_q;
      end
    end

    assign lvl[g]  = lvl_q;
    assign rise[g] = lvl_q & ~prv_q;
    assign fall[g] = ~lvl_q & prv_q;
  end
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_cmd_rx_pkg::*;
#(
  parameter int                BYTE_W  = 8,
  parameter logic [BYTE_W-3:0] ADDR_HI = 6'b110111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              addr_sel,
  output logic              pull,
  output logic [BYTE_W-1:0] data,
  output logic              valid
);
  localparam int              CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  rx_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              pull_q, pull_d;
  logic              vld_q, vld_d;
  logic              start_ev, stop_ev;
  logic              bit_en, byte_end;
  logic [BYTE_W-1:0] own_addr;

  assign start_ev = sda_fall & scl_lvl;
  assign stop_ev  = sda_rise & scl_lvl;
  assign own_addr = {ADDR_HI, addr_sel, 1'b0};
  assign bit_en   = scl_rise & (cnt_q != CNT_FULL);
  assign byte_end = scl_fall & (cnt_q == CNT_FULL);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    dat_d  = dat_q;
    pull_d = pull_q;
    vld_d  = 1'b0;
    if (stop_ev) begin
      st_d   = RX_IDLE;
      pull_d = 1'b0;
    end else if (start_ev) begin
      st_d   = RX_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else begin
      unique case (st_q)
        RX_ADDR, RX_DATA: begin
          if (bit_en) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_end) begin
            if (st_q == RX_DATA) begin
              dat_d  = sh_q;
              vld_d  = 1'b1;
              pull_d = 1'b1;
              st_d   = RX_ACK;
            end else if (sh_q == own_addr) begin
              pull_d = 1'b1;
              st_d   = RX_ACK;
            end else begin
              st_d = RX_SKIP;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            st_d   = RX_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      dat_q  <= '0;
      pull_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      dat_q  <= dat_d;
      pull_q <= pull_d;
      vld_q  <= vld_d;
    end
  end

  assign pull  = pull_q;
  assign data  = dat_q;
  assign valid = vld_q;
endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx
  import i2c_cmd_rx_pkg::*;
#(
  parameter int                BYTE_W     = 8,
  parameter int                SYNC_DEPTH = 2,
  parameter int                FILT_LEN   = 3,
  parameter logic [BYTE_W-3:0] ADDR_HI    = 6'b110111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_valid
);
  logic                rst_n_s;
  logic [LINE_NUM-1:0] lines, lvl, rise, fall;

  assign lines[LINE_SCL] = scl_i;
  assign lines[LINE_SDA] = sda_i;

  i2c_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  i2c_line_cond #(.N(LINE_NUM), .SYNC(SYNC_DEPTH), .FILT(FILT_LEN)) u_cond (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (lines),
    .lvl   (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  i2c_rx_fsm #(.BYTE_W(BYTE_W), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_lvl  (lvl[LINE_SCL]),
    .sda_lvl  (lvl[LINE_SDA]),
    .scl_rise (rise[LINE_SCL]),
    .scl_fall (fall[LINE_SCL]),
    .sda_rise (rise[LINE_SDA]),
    .sda_fall (fall[LINE_SDA]),
    .addr_sel (addr_sel),
    .pull     (sda_pull),
    .data     (cmd_data),
    .valid    (cmd_valid)
  );
endmodule

// File: rtl/i2c_cmd_rx_chk.sv
module i2c_cmd_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull,
  input logic cmd_valid
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sda_pull && !cmd_valid);
    end
  end

  // R4
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R5
  ack_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> sda_pull);

  // R10
  pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  // R10
  release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_i);
endmodule

bind i2c_cmd_rx i2c_cmd_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_pull  (sda_pull),
  .cmd_valid (cmd_valid)
);

// File: tb/tb_i2c_cmd_rx.sv
module tb_i2c_cmd_rx;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n, m_scl, m_sda, strap;
  logic       sda_bus, sda_pull, cmd_valid;
  logic [7:0] cmd_data;
  logic [7:0] rx_mem [0:63];
  int         rx_n = 0;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull;

  i2c_cmd_rx dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .addr_sel  (strap),
    .sda_pull  (sda_pull),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid)
  );

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      rx_mem[rx_n % 64] = cmd_data;
      rx_n++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(2*Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(2*Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic bus_bit(input logic b, input bit gl, output logic s);
    m_sda = b; tick(Q);
    m_scl = 1'b1;
    if (gl) begin
      tick(2); m_scl = 1'b0; tick(2); m_scl = 1'b1; tick(1);
    end else begin
      tick(Q);
    end
    s = sda_bus;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], gl, s);
    bus_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bus_bit(b[i], 1'b0, s);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    done();
  end

  initial begin
    bit         a1, a2;
    int         base;
    logic [7:0] exp_addr, dv;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 1'b0;
    tick(4);
    // R1: quiet during reset
    chk(!sda_pull && !cmd_valid, "R1 reset", {sda_pull, cmd_valid}, 0);
    rst_n = 1'b1;
    tick(6);
    chk(!sda_pull && !cmd_valid, "R1 after reset", {sda_pull, cmd_valid}, 0);

    // R2/R3/R4/R5: full first-byte sweep, strap low (own byte 0xDC)
    for (int a = 0; a < 256; a++) begin
      base = rx_n;
      dv   = 8'(a) ^ 8'h5A;
      bus_start();
      send_byte(8'(a), 1'b0, a1);
      send_byte(dv, 1'b0, a2);
      bus_stop();
      if (a == 8'hDC) begin
        chk(a1, "R2 addr ack", a1, 1);
        chk(a2, "R5 data ack", a2, 1);
        chk(rx_n - base == 1, "R4 strobe count", rx_n - base, 1);
        chk(rx_mem[base % 64] == dv, "R4 data", rx_mem[base % 64], dv);
      end else begin
        chk(!a1, "R3 addr nack", a1, 0);
        chk(!a2 && rx_n == base, "R3 ignored byte", {a2, 1'b0} | (rx_n - base), 0);
      end
    end

    // R2: strap high selects 0xDE
    strap = 1'b1; tick(4);
    for (int k = 0; k < 4; k++) begin
      exp_addr = 8'hDC + 8'(k);
      base = rx_n;
      bus_start();
      send_byte(exp_addr, 1'b0, a1);
      send_byte(8'h99, 1'b0, a2);
      bus_stop();
      chk(a1 == (exp_addr == 8'hDE), "R2 strap addr", a1, exp_addr == 8'hDE);
      chk((rx_n - base) == int'(exp_addr == 8'hDE), "R2 strap strobe", rx_n - base, exp_addr == 8'hDE);
    end
    strap = 1'b0; tick(4);

    // R6: long transaction
    base = rx_n;
    bus_start();
    send_byte(8'hDC, 1'b0, a1);
    for (int k = 0; k < 20; k++) begin
      send_byte(8'(k * 37 + 11), 1'b0, a2);
      chk(a2, "R6 ack each", a2, 1);
    end
    bus_stop();
    chk(rx_n - base == 20, "R6 count", rx_n - base, 20);
    for (int k = 0; k < 20; k++)
      chk(rx_mem[(base + k) % 64] == 8'(k * 37 + 11), "R6 order", rx_mem[(base + k) % 64], 8'(k * 37 + 11));

    // R7: STOP in mid-byte
    base = rx_n;
    bus_start();
    send_byte(8'hDC, 1'b0, a1);
    send_bits(8'hF0, 4);
    bus_stop();
    chk(rx_n == base, "R7 partial dropped", rx_n - base, 0);
    bus_start();
    send_byte(8'hDC, 1'b0, a1);
    send_byte(8'h42, 1'b0, a2);
    bus_stop();
    chk(rx_n - base == 1 && rx_mem[base % 64] == 8'h42, "R7 next ok", rx_mem[base % 64], 8'h42);

    // R8: repeated START mid-byte, and after a rejected address
    base = rx_n;
    bus_start();
    send_byte(8'hDC, 1'b0, a1);
    send_bits(8'hA0, 3);
    bus_start();
    send_byte(8'hDC, 1'b0, a1);
    send_byte(8'h3C, 1'b0, a2);
    bus_stop();
    chk(rx_n - base == 1 && rx_mem[base % 64] == 8'h3C, "R8 restart", rx_mem[base % 64], 8'h3C);
    base = rx_n;
    bus_start();
    send_byte(8'h90, 1'b0, a1);
    bus_start();
    send_byte(8'hDC, 1'b0, a1);
    chk(a1, "R8 rematch ack", a1, 1);
    send_byte(8'h81, 1'b0, a2);
    bus_stop();
    chk(rx_n - base == 1 && rx_mem[base % 64] == 8'h81, "R8 after reject", rx_mem[base % 64], 8'h81);

    // R9: short clock glitches in every high phase
    base = rx_n;
    bus_start();
    send_byte(8'hDC, 1'b1, a1);
    send_byte(8'hB6, 1'b1, a2);
    bus_stop();
    chk(a1 && a2, "R9 glitch ack", {a1, a2}, 3);
    chk(rx_n - base == 1 && rx_mem[base % 64] == 8'hB6, "R9 glitch data", rx_mem[base % 64], 8'hB6);

    tick(10);
    done();
  end
endmodule